// File: doc/BRIEF.md
# Coprocessor Status and Semaphore Register Block

This block holds the run-control and signalling state of an attached signal coprocessor and exposes it on a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the read strobe. Software changes the stop, break, interrupt, single-step and break-interrupt flags and a bank of general signal flags by writing command words. Each command word carries a separate set bit and a separate clear bit for every flag. It reads the flags back through a status word whose layout differs from the command layout.

The block also reports three live indications from neighbouring logic as read-only bits: transfer engine busy, transfer queue full and I/O full. It offers a one-bit hardware lock for sharing the coprocessor between software agents. A read of the lock register returns the lock's previous value and takes the lock in the same access. Any write to that register frees it. The interrupt request output, the stop output and the single-step output follow their flags. A break pulse from the core marks the break flag and can raise the interrupt as well.

Top module: `coproc_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, the stop flag is 1. Every other flag and the lock are 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: A write to byte offset 0x10 acts on the flags as follows:
  - bit 0 clears the stop flag; bit 1 sets it.
  - bit 2 clears the break flag.
  - bit 3 clears the interrupt flag; bit 4 sets it.
  - bit 5 clears single-step; bit 6 sets it.
  - bit 7 clears break-interrupt enable; bit 8 sets it.
- R3: Signal flag n (n = 0..7) is cleared by write bit 9+2n and set by write bit 10+2n of a write to offset 0x10.
- R4: When a flag's set bit and clear bit are both 1 in one write, that flag keeps its value. When both are 0, it also keeps its value.
- R5: A read of offset 0x10 returns the status word below. Bits 31..15 read 0, and the interrupt flag does not appear in this word.

  | Bit | Content |
  |-----|---------|
  | 0 | stop |
  | 1 | break |
  | 2 | transfer busy input |
  | 3 | transfer full input |
  | 4 | I/O full input |
  | 5 | single-step |
  | 6 | break-interrupt enable |
  | 7..14 | signal flags 0..7 |

- R6: A read of offset 0x14 returns the transfer full input in bit 0. A read of offset 0x18 returns the transfer busy input in bit 0. All other bits of both reads are 0.
- R7: A read of offset 0x1C returns the lock's previous value in bit 0 and leaves the lock at 1. Any write to offset 0x1C leaves it at 0, and a write wins over a read in the same cycle.
- R8: A one-cycle `core_break_i` pulse sets the break flag. If break-interrupt enable is 1 at that moment, the pulse also sets the interrupt flag. A break pulse wins over a clear command in the same cycle.
- R9: `irq_o`, `halt_o` and `sstep_o` equal the interrupt, stop and single-step flags at all times.
- R10: Read data is valid in the cycle after `bus_rd`, and `bus_rdata` is 0 in any cycle that does not follow a read. Reads of unmapped offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| dma_busy_i | input | 1 | Transfer engine busy indication |
| dma_full_i | input | 1 | Transfer queue full indication |
| io_full_i | input | 1 | I/O full indication |
| core_break_i | input | 1 | One-cycle break pulse from the core |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Stop request to the core |
| sstep_o | output | 1 | Single-step mode to the core |

## Verification
The assertions check the cycle-level rules on every cycle:
- the reset values;
- the stop flag's response to a pure set and to a contradictory set-plus-clear;
- the lock being taken by a read and freed by a write;
- the value a read of a held lock returns;
- break marking the break flag and, when enabled, the interrupt;
- idle read data being zero.

The bench's scenarios show the behaviours that only appear in full field layouts:
- the full status word layout with every signal-flag bit position;
- the separate busy and full registers;
- that unmapped offsets do not respond;
- the ordering of competing break and clear events.

// File: rtl/coproc_ctl_pkg.sv
// Package: shared offsets and bit positions of the coprocessor control registers.
// Assumes a 32-bit data bus and byte addressing with word-aligned registers.
package coproc_ctl_pkg;

    // Byte offsets of the decoded registers
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_DFULL  = 'h14;
    localparam int OFS_DBUSY  = 'h18;
    localparam int OFS_LOCK   = 'h1C;

    // Command (write) bit positions
    localparam int WB_HALT_CLR  = 0;
    localparam int WB_HALT_SET  = 1;
    localparam int WB_BRK_CLR   = 2;
    localparam int WB_INT_CLR   = 3;
    localparam int WB_INT_SET   = 4;
    localparam int WB_STEP_CLR  = 5;
    localparam int WB_STEP_SET  = 6;
    localparam int WB_BIE_CLR   = 7;
    localparam int WB_BIE_SET   = 8;
    localparam int WB_SIG_BASE  = 9;   // clear = base+2n, set = base+2n+1

    // Status (read) bit positions
    localparam int RB_HALT     = 0;
    localparam int RB_BRK      = 1;
    localparam int RB_DBUSY    = 2;
    localparam int RB_DFULL    = 3;
    localparam int RB_IOFULL   = 4;
    localparam int RB_STEP     = 5;
    localparam int RB_BIE      = 6;
    localparam int RB_SIG_BASE = 7;

endpackage

// File: rtl/ccr_flag.sv
// Module: one flag with separate set and clear commands plus a hardware set.
// Assumes hw_set has priority; set together with clear leaves the flag unchanged.
module ccr_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic hw_set,
    output logic q
);

    // Update the flag from hardware event or software command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (hw_set) begin
            q <= 1'b1;
        end else if (set_cmd && !clr_cmd) begin
            q <= 1'b1;
        end else if (clr_cmd && !set_cmd) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/ccr_lock.sv
// Module: one-bit hardware lock, taken by a read and freed by a write.
// Assumes a write in the same cycle as a read wins and leaves the lock free.
module ccr_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic free,
    output logic q
);

    // Track lock ownership
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (free) begin
            q <= 1'b0;
        end else if (take) begin
            q <= 1'b1;
        end
    end

endmodule

// File: rtl/ccr_rdmux.sv
// Module: registered read-data selector over the decoded register set.
// Assumes at most one select is active; returns zero when no read is pending.
module ccr_rdmux #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              sel_status,
    input  logic              sel_dfull,
    input  logic              sel_dbusy,
    input  logic              sel_lock,
    input  logic [DATA_W-1:0] status_word,
    input  logic              dma_full,
    input  logic              dma_busy,
    input  logic              lock_q,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel_word;

    // Pick the word addressed by the current read
    always_comb begin
        sel_word = '0;
        if (sel_status) sel_word = status_word;
        if (sel_dfull)  sel_word = DATA_W'(dma_full);
        if (sel_dbusy)  sel_word = DATA_W'(dma_busy);
        if (sel_lock)   sel_word = DATA_W'(lock_q);
    end

    // Register the read result for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= sel_word;
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/coproc_ctl_regs.sv
// Module: status/command register block of an attached signal coprocessor.
// Holds run-control flags and signal flags changed by paired set/clear command
// bits, reports transfer and I/O indications, and provides a read-to-take lock.
// Assumes a single-cycle bus access per strobe and a one-cycle break pulse.
module coproc_ctl_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NSIG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_busy_i,
    input  logic              dma_full_i,
    input  logic              io_full_i,
    input  logic              core_break_i,
    output logic              irq_o,
    output logic              halt_o,
    output logic              sstep_o
);
    import coproc_ctl_pkg::*;

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IDX_STATUS = IDX_W'(OFS_STATUS >> 2);
    localparam logic [IDX_W-1:0] IDX_DFULL  = IDX_W'(OFS_DFULL >> 2);
    localparam logic [IDX_W-1:0] IDX_DBUSY  = IDX_W'(OFS_DBUSY >> 2);
    localparam logic [IDX_W-1:0] IDX_LOCK   = IDX_W'(OFS_LOCK >> 2);

    logic [IDX_W-1:0] widx;
    logic sel_status, sel_dfull, sel_dbusy, sel_lock;
    logic cmd_wr;
    logic halt_q, broke_q, intr_q, sstep_q, ieb_q, sem_q;
    logic [NSIG-1:0] sig_q;
    logic [DATA_W-1:0] status_word;

    // Decode the word index of the access
    always_comb begin
        widx       = bus_addr[ADDR_W-1:2];
        sel_status = (widx == IDX_STATUS);
        sel_dfull  = (widx == IDX_DFULL);
        sel_dbusy  = (widx == IDX_DBUSY);
        sel_lock   = (widx == IDX_LOCK);
        cmd_wr     = bus_wr && sel_status;
    end

    ccr_flag #(.RST_VAL(1'b1)) u_halt (
        .clk(clk), .rst_n(rst_n),
        .set_cmd(cmd_wr && bus_wdata[WB_HALT_SET]),
        .clr_cmd(cmd_wr && bus_wdata[WB_HALT_CLR]),
        .hw_set(1'b0), .q(halt_q));

    ccr_flag #(.RST_VAL(1'b0)) u_broke (
        .clk(clk), .rst_n(rst_n),
        .set_cmd(1'b0),
        .clr_cmd(cmd_wr && bus_wdata[WB_BRK_CLR]),
        .hw_set(core_break_i), .q(broke_q));

    ccr_flag #(.RST_VAL(1'b0)) u_intr (
        .clk(clk), .rst_n(rst_n),
        .set_cmd(cmd_wr && bus_wdata[WB_INT_SET]),
        .clr_cmd(cmd_wr && bus_wdata[WB_INT_CLR]),
        .hw_set(core_break_i && ieb_q), .q(intr_q));

    ccr_flag #(.RST_VAL(1'b0)) u_sstep (
        .clk(clk), .rst_n(rst_n),
        .set_cmd(cmd_wr && bus_wdata[WB_STEP_SET]),
        .clr_cmd(cmd_wr && bus_wdata[WB_STEP_CLR]),
        .hw_set(1'b0), .q(sstep_q));

    ccr_flag #(.RST_VAL(1'b0)) u_ieb (
        .clk(clk), .rst_n(rst_n),
        .set_cmd(cmd_wr && bus_wdata[WB_BIE_SET]),
        .clr_cmd(cmd_wr && bus_wdata[WB_BIE_CLR]),
        .hw_set(1'b0), .q(ieb_q));

    // One flag cell per general signal
    generate
        for (genvar n = 0; n < NSIG; n++) begin : g_sig
            ccr_flag #(.RST_VAL(1'b0)) u_sig (
                .clk(clk), .rst_n(rst_n),
                .set_cmd(cmd_wr && bus_wdata[WB_SIG_BASE + 2*n + 1]),
                .clr_cmd(cmd_wr && bus_wdata[WB_SIG_BASE + 2*n]),
                .hw_set(1'b0), .q(sig_q[n]));
        end
    endgenerate

    ccr_lock u_lock (
        .clk(clk), .rst_n(rst_n),
        .take(bus_rd && sel_lock),
        .free(bus_wr && sel_lock),
        .q(sem_q));

    // Assemble the status read word
    always_comb begin
        status_word            = '0;
        status_word[RB_HALT]   = halt_q;
        status_word[RB_BRK]    = broke_q;
        status_word[RB_DBUSY]  = dma_busy_i;
        status_word[RB_DFULL]  = dma_full_i;
        status_word[RB_IOFULL] = io_full_i;
        status_word[RB_STEP]   = sstep_q;
        status_word[RB_BIE]    = ieb_q;
        for (int i = 0; i < NSIG; i++) begin
            status_word[RB_SIG_BASE + i] = sig_q[i];
        end
    end

    ccr_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd),
        .sel_status(sel_status), .sel_dfull(sel_dfull),
        .sel_dbusy(sel_dbusy), .sel_lock(sel_lock),
        .status_word(status_word),
        .dma_full(dma_full_i), .dma_busy(dma_busy_i),
        .lock_q(sem_q), .rdata(bus_rdata));

    // Drive the control outputs from the flags
    always_comb begin
        irq_o   = intr_q;
        halt_o  = halt_q;
        sstep_o = sstep_q;
    end

endmodule

// File: rtl/coproc_ctl_regs_chk.sv
// Module: assertion checker bound to coproc_ctl_regs.
// Assumes visibility of the break-enable, break and lock state through the bind.
module coproc_ctl_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_break_i,
    input logic              irq_o,
    input logic              halt_o,
    input logic              broke_q,
    input logic              ieb_q,
    input logic              sem_q
);
    import coproc_ctl_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic at_status, at_lock;

    // Decode the two offsets the properties refer to
    always_comb begin
        at_status = (bus_addr[ADDR_W-1:2] == IDX_W'(OFS_STATUS >> 2));
        at_lock   = (bus_addr[ADDR_W-1:2] == IDX_W'(OFS_LOCK >> 2));
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (halt_o && !irq_o && !sem_q && bus_rdata == '0));

    p_halt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_status && bus_wdata[WB_HALT_SET] && !bus_wdata[WB_HALT_CLR])
        |=> halt_o);

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_status && bus_wdata[WB_HALT_SET] && bus_wdata[WB_HALT_CLR])
        |=> $stable(halt_o));

    p_lock_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_lock && !bus_wr) |=> sem_q);

    p_lock_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_lock) |=> !sem_q);

    p_lock_held_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_lock && sem_q) |=> (bus_rdata == DATA_W'(1)));

    p_break_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_break_i |=> broke_q);

    p_break_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_break_i && ieb_q) |=> irq_o);

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind coproc_ctl_regs coproc_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .core_break_i(core_break_i), .irq_o(irq_o), .halt_o(halt_o),
    .broke_q(broke_q), .ieb_q(ieb_q), .sem_q(sem_q));

// File: tb/coproc_ctl_regs_tb.sv
`timescale 1ns/1ps
module coproc_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        dma_busy_i = 1'b0, dma_full_i = 1'b0, io_full_i = 1'b0;
    logic        core_break_i = 1'b0;
    logic        irq_o, halt_o, sstep_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    coproc_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .dma_busy_i(dma_busy_i), .dma_full_i(dma_full_i), .io_full_i(io_full_i),
        .core_break_i(core_break_i), .irq_o(irq_o), .halt_o(halt_o), .sstep_o(sstep_o));

    // Behavioural reference model
    bit m_halt, m_brk, m_int, m_step, m_bie, m_lock;
    bit [7:0] m_sig;
    bit [31:0] m_rdata;

    function automatic bit upd(bit old, bit s, bit c);
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        return old;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_halt = 1; m_brk = 0; m_int = 0; m_step = 0; m_bie = 0;
            m_lock = 0; m_sig = 0; m_rdata = 0;
        end else begin
            bit [31:0] st;
            bit cw;
            st = 0;
            st[0] = m_halt; st[1] = m_brk; st[2] = dma_busy_i; st[3] = dma_full_i;
            st[4] = io_full_i; st[5] = m_step; st[6] = m_bie;
            for (int k = 0; k < 8; k++) st[7+k] = m_sig[k];
            if (bus_rd) begin
                case (bus_addr)
                    8'h10: m_rdata = st;
                    8'h14: m_rdata = {31'd0, dma_full_i};
                    8'h18: m_rdata = {31'd0, dma_busy_i};
                    8'h1C: m_rdata = {31'd0, m_lock};
                    default: m_rdata = 0;
                endcase
            end else m_rdata = 0;
            if (bus_wr && bus_addr == 8'h1C) m_lock = 0;
            else if (bus_rd && bus_addr == 8'h1C) m_lock = 1;
            cw = bus_wr && bus_addr == 8'h10;
            if (core_break_i && m_bie) m_int = 1;
            else m_int = upd(m_int, cw && bus_wdata[4], cw && bus_wdata[3]);
            if (core_break_i) m_brk = 1;
            else m_brk = upd(m_brk, 1'b0, cw && bus_wdata[2]);
            m_halt = upd(m_halt, cw && bus_wdata[1], cw && bus_wdata[0]);
            m_step = upd(m_step, cw && bus_wdata[6], cw && bus_wdata[5]);
            m_bie  = upd(m_bie,  cw && bus_wdata[8], cw && bus_wdata[7]);
            for (int k = 0; k < 8; k++)
                m_sig[k] = upd(m_sig[k], cw && bus_wdata[10+2*k], cw && bus_wdata[9+2*k]);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq_o", {31'd0, irq_o}, {31'd0, m_int});
            chk("R9 halt_o", {31'd0, halt_o}, {31'd0, m_halt});
            chk("R9 sstep_o", {31'd0, sstep_o}, {31'd0, m_step});
            chk("R5/R10 rdata model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic brk_pulse(input logic [31:0] d, input bit with_wr);
        @(negedge clk); core_break_i = 1;
        if (with_wr) begin bus_addr = 8'h10; bus_wdata = d; bus_wr = 1; end
        @(negedge clk); core_break_i = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset halt_o", {31'd0, halt_o}, 32'd1);
        chk("R1 reset irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 reset rdata", bus_rdata, 32'd0);
        rst_n = 1;
        rd_chk(8'h10, 32'h1, "R1 status after reset");
        rd_chk(8'h1C, 32'h0, "R1 lock free after reset");
        wr(8'h1C, 0);
        wr(8'h10, 32'h1);
        rd_chk(8'h10, 32'h0, "R2 halt cleared");
        wr(8'h10, 32'h10);
        chk("R9 irq after set", {31'd0, irq_o}, 32'd1);
        rd_chk(8'h10, 32'h0, "R5 intr not in status");
        wr(8'h10, 32'h8);
        chk("R2 irq after clear", {31'd0, irq_o}, 32'd0);
        wr(8'h10, 32'h140);
        chk("R9 sstep_o set", {31'd0, sstep_o}, 32'd1);
        rd_chk(8'h10, 32'h60, "R2 sstep and break-enable");
        wr(8'h10, (32'd1 << 16) | (32'd1 << 24));
        rd_chk(8'h10, 32'h4460, "R3 signal 3 and 7 set");
        wr(8'h10, 32'd1 << 15);
        rd_chk(8'h10, 32'h4060, "R3 signal 3 cleared");
        wr(8'h10, 32'h3);
        rd_chk(8'h10, 32'h4060, "R4 both halt bits, halt stays 0");
        wr(8'h10, 32'h2);
        wr(8'h10, 32'h3);
        rd_chk(8'h10, 32'h4061, "R4 both halt bits, halt stays 1");
        wr(8'h10, 32'h0);
        rd_chk(8'h10, 32'h4061, "R4 zero write no change");
        @(negedge clk); dma_busy_i = 1; io_full_i = 1;
        rd_chk(8'h18, 32'h1, "R6 busy register");
        rd_chk(8'h14, 32'h0, "R6 full register idle");
        rd_chk(8'h10, 32'h4075, "R5 live input bits");
        @(negedge clk); dma_busy_i = 0; dma_full_i = 1; io_full_i = 0;
        rd_chk(8'h14, 32'h1, "R6 full register");
        rd_chk(8'h18, 32'h0, "R6 busy register idle");
        rd_chk(8'h10, 32'h4069, "R5 full bit");
        @(negedge clk); dma_full_i = 0;
        rd_chk(8'h1C, 32'h0, "R7 first take returns free");
        rd_chk(8'h1C, 32'h1, "R7 second take returns held");
        wr(8'h1C, 32'h0);
        rd_chk(8'h1C, 32'h0, "R7 released by write");
        @(negedge clk); bus_addr = 8'h1C; bus_rd = 1; bus_wr = 1;
        @(negedge clk); bus_rd = 0; bus_wr = 0;
        chk("R7 same-cycle read value", bus_rdata, 32'h1);
        rd_chk(8'h1C, 32'h0, "R7 write wins over read");
        wr(8'h1C, 0);
        brk_pulse(0, 0);
        chk("R8 break raises irq when enabled", {31'd0, irq_o}, 32'd1);
        rd_chk(8'h10, 32'h4063, "R8 break flag set");
        wr(8'h10, 32'hC);
        rd_chk(8'h10, 32'h4061, "R2 break cleared");
        chk("R2 irq cleared", {31'd0, irq_o}, 32'd0);
        wr(8'h10, 32'h80);
        brk_pulse(0, 0);
        chk("R8 break without enable keeps irq", {31'd0, irq_o}, 32'd0);
        rd_chk(8'h10, 32'h4023, "R8 break flag only");
        wr(8'h10, 32'h4);
        brk_pulse(32'h4, 1);
        rd_chk(8'h10, 32'h4023, "R8 break wins over clear");
        rd_chk(8'h00, 32'h0, "R10 unmapped read 0x00");
        rd_chk(8'h20, 32'h0, "R10 unmapped read 0x20");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h4023, "R10 unmapped write ignored");
        chk("R10 irq after unmapped write", {31'd0, irq_o}, 32'd0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule